// File: doc/BRIEF.md
# Four-Channel Digital Potentiometer Serial Controller

This block is the digital control core of a four-channel digital potentiometer. A host sends it 16-bit command frames over a three-wire serial bus: the serial clock, serial data in and an active-low select. The core holds one 8-bit scratchpad value for each wiper and a 2-bit general-purpose output register. Each of these has a modelled nonvolatile shadow register. The scratchpad values drive the wiper and output ports directly. The resistor network and real EEPROM timing lie outside the block. Nonvolatile storage is a register array with a fixed busy window.

All serial pins are sampled in the system clock domain, and their edges are found there. Bits enter on each rising serial clock edge while select is low. A frame is acted on only when select returns high. The serial output normally repeats the input stream sixteen shift clocks later, so several devices can share one chain. After a readback command, the next frame shifts out a register value instead. A write-protect pin, a preset pin and a ready flag complete the interface. There are two resets. `por` is the power-on reset and sets the nonvolatile contents to their factory defaults. `rst` is the synchronous reset and reloads the scratchpads from the nonvolatile contents.

Top module: `dpot_ctrl`

## Requirements
- R1: While `cs_n` is low, each rising edge of `sclk` shifts one bit of `sdi` into the frame, most significant bit first. In the frame, bits [15:12] are the command, bits [11:8] are the address and bits [7:0] are the data.
- R2: A frame runs only on the rising edge of `cs_n`, and only if exactly 16 bits were shifted since the previous rising edge of `cs_n`. Frames of any other length are ignored.
- R3: `sdo` shows the bit that was shifted in 16 shift clocks earlier. It changes only on a shift or on a readback load.
- R4: Command 1 writes the data byte to a scratchpad. Addresses 0 to 3 select wiper channels 0 to 3. Address 4 selects the output register: data bit 0 goes to `dout[0]` and data bit 1 goes to `dout[1]`. An address above 4 changes nothing.
- R5: Command 2 copies the addressed scratchpad into its nonvolatile shadow. Command 3 copies the addressed shadow back into its scratchpad. Command 8 copies every shadow back into its scratchpad.
- R6: Command 9 (shadow) and command 10 (scratchpad) load the 16-bit word {command, address, value} into the output shift path. The next frame shifts this word out on `sdo`, most significant bit first.
- R7: While `wp_n` is low, commands 1 and 2 have no effect and do not start a busy window. Restores, readbacks, preset and reset still work.
- R8: A rising edge on `preset` reloads every scratchpad from its shadow. A frame that completes in the same cycle is ignored.
- R9: After `por`, each wiper shadow and each wiper scratchpad is 0x20, and the output register and its shadow are 0.
- R10: Commands 2, 3, 8, 9 and 10 drive `ready` low for BUSY_CYC cycles. Frames that complete while `ready` is low are ignored.
- R11: `rst` reloads every scratchpad from its shadow, sets `ready` high, clears the bit count and sets the `sdo` path to 0. The shadows are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por | input | 1 | Power-on reset, synchronous, restores the factory shadow contents |
| rst | input | 1 | Synchronous reset of the control state |
| sclk | input | 1 | Serial shift clock |
| sdi | input | 1 | Serial data in |
| cs_n | input | 1 | Active-low frame select |
| wp_n | input | 1 | Active-low write protect |
| preset | input | 1 | Reload request, acts on its rising edge |
| sdo | output | 1 | Serial data out |
| ready | output | 1 | High when no nonvolatile operation is in progress |
| wiper | output | NCH*DW | Wiper scratchpads, channel i in bits [i*DW +: DW] |
| dout | output | 2 | Output register |

## Verification
The hardest case to reach is a well-formed frame that ends inside the busy window. A real host would wait for `ready` before sending it. The bench uses a busy window longer than one complete frame. It sends a store and then, without polling `ready`, sends a write at once, so the write's select edge lands while `ready` is still low. Readback is checked by capturing `sdo` across the frame that follows the readback command.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
   localparam int CMD_W = 4;
   localparam int ADR_W = 4;
   localparam int OUT_BITS = 2;

   typedef enum logic [CMD_W-1:0] {
      OP_NOP      = 4'd0,
      OP_WRITE    = 4'd1,
      OP_STORE    = 4'd2,
      OP_RESTORE  = 4'd3,
      OP_RECALL   = 4'd8,
      OP_READ_NV  = 4'd9,
      OP_READ_SCR = 4'd10
   } op_e;
endpackage

// File: rtl/dpot_frame_rx.sv
module dpot_frame_rx #(
   parameter int FRAME_W = 16
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               sclk,
   input  logic               sdi,
   input  logic               cs_n,
   input  logic               load,
   input  logic [FRAME_W-1:0] load_word,
   output logic               frame_ok,
   output logic [FRAME_W-1:0] frame,
   output logic               sdo
);
   localparam int CNT_W = $clog2(FRAME_W + 2);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);
   localparam logic [CNT_W-1:0] OVER = CNT_W'(FRAME_W + 1);

   if (FRAME_W < 2) begin : g_bad_width
      $error("dpot_frame_rx: FRAME_W must be at least 2");
   end

   logic               sclk_q, cs_q;
   logic [FRAME_W-1:0] shreg;
   logic [CNT_W-1:0]   cnt;
   logic               shift, cs_rise;

   assign shift   = sclk && !sclk_q && !cs_n;
   assign cs_rise = cs_n && !cs_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         sclk_q <= 1'b1;
         cs_q   <= 1'b1;
         shreg  <= '0;
         cnt    <= '0;
      end else begin
         sclk_q <= sclk;
         cs_q   <= cs_n;
         if (load)       shreg <= load_word;
         else if (shift) shreg <= {shreg[FRAME_W-2:0], sdi};
         if (cs_rise)                   cnt <= '0;
         else if (shift && cnt != OVER) cnt <= cnt + 1'b1;
      end
   end

   assign frame_ok = cs_rise && (cnt == FULL);
   assign frame    = shreg;
   assign sdo      = shreg[FRAME_W-1];

   AST_SDO_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!shift && !load) |=> $stable(sdo)); // R3
endmodule

// File: rtl/dpot_regfile.sv
module dpot_regfile #(
   parameter int          NCH      = 4,
   parameter int          DW       = 8,
   parameter int          OUT_BITS = 2,
   parameter logic [7:0]  NV_DEF   = 8'h20,
   localparam int         NREG     = NCH + 1,
   localparam int         AW       = $clog2(NREG)
) (
   input  logic               clk,
   input  logic               por,
   input  logic               rst,
   input  logic               recall_all,
   input  logic               wr_en,
   input  logic [AW-1:0]      wr_idx,
   input  logic [DW-1:0]      wr_data,
   input  logic               st_en,
   input  logic [AW-1:0]      st_idx,
   input  logic               rs_en,
   input  logic [AW-1:0]      rs_idx,
   output logic [NREG*DW-1:0] scr_flat,
   output logic [NREG*DW-1:0] nv_flat
);
   if (OUT_BITS > DW || DW < 8) begin : g_bad_width
      $error("dpot_regfile: DW must be at least 8 and hold OUT_BITS");
   end

   for (genvar i = 0; i < NREG; i++) begin : g_ent
      localparam logic [DW-1:0] DEF  = (i < NCH) ? DW'(NV_DEF) : '0;
      localparam logic [DW-1:0] MASK = (i < NCH) ? {DW{1'b1}} : DW'((1 << OUT_BITS) - 1);
      logic [DW-1:0] scr_q, nv_q;

      always_ff @(posedge clk) begin
         if (por)
            scr_q <= DEF;
         else if (rst || recall_all || (rs_en && rs_idx == AW'(i)))
            scr_q <= nv_q;
         else if (wr_en && wr_idx == AW'(i))
            scr_q <= wr_data & MASK;
      end

      always_ff @(posedge clk) begin
         if (por)                            nv_q <= DEF;
         else if (st_en && st_idx == AW'(i)) nv_q <= scr_q;
      end

      assign scr_flat[i*DW +: DW] = scr_q;
      assign nv_flat[i*DW +: DW]  = nv_q;
   end
endmodule

// File: rtl/dpot_busy_timer.sv
module dpot_busy_timer #(
   parameter int BUSY_CYC = 64
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic busy
);
   localparam int CW = $clog2(BUSY_CYC + 1);

   if (BUSY_CYC < 1) begin : g_bad_cyc
      $error("dpot_busy_timer: BUSY_CYC must be at least 1");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)              cnt <= '0;
      else if (start)       cnt <= CW'(BUSY_CYC);
      else if (cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);

   AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
      start |-> !busy); // R10
endmodule

// File: rtl/dpot_ctrl.sv
module dpot_ctrl
   import dpot_pkg::*;
#(
   parameter int         NCH      = 4,
   parameter int         DW       = 8,
   parameter logic [7:0] NV_DEF   = 8'h20,
   parameter int         BUSY_CYC = 64
) (
   input  logic              clk,
   input  logic              por,
   input  logic              rst,
   input  logic              sclk,
   input  logic              sdi,
   input  logic              cs_n,
   input  logic              wp_n,
   input  logic              preset,
   output logic              sdo,
   output logic              ready,
   output logic [NCH*DW-1:0] wiper,
   output logic [1:0]        dout
);
   localparam int FRAME_W = CMD_W + ADR_W + DW;
   localparam int NREG    = NCH + 1;
   localparam int AW      = $clog2(NREG);

   if (AW > ADR_W) begin : g_bad_nch
      $error("dpot_ctrl: NCH too large for the address field");
   end

   logic               any_rst;
   logic               frame_ok, busy, pre_q, pre_rise, go;
   logic [FRAME_W-1:0] frame, load_word;
   logic [CMD_W-1:0]   cmd;
   logic [ADR_W-1:0]   addr;
   logic [DW-1:0]      data, rb_val;
   logic               addr_ok;
   logic [AW-1:0]      idx;
   logic               wr_en, st_en, rs_en, recall, rb, start;
   logic [NREG*DW-1:0] scr_flat, nv_flat;

   assign any_rst = por || rst;

   dpot_frame_rx #(.FRAME_W(FRAME_W)) u_rx (
      .clk(clk), .rst(any_rst), .sclk(sclk), .sdi(sdi), .cs_n(cs_n),
      .load(rb), .load_word(load_word), .frame_ok(frame_ok),
      .frame(frame), .sdo(sdo));

   always_ff @(posedge clk) begin
      if (any_rst) pre_q <= preset;
      else         pre_q <= preset;
   end
   assign pre_rise = preset && !pre_q && !any_rst;

   assign cmd     = frame[FRAME_W-1 -: CMD_W];
   assign addr    = frame[DW +: ADR_W];
   assign data    = frame[DW-1:0];
   assign addr_ok = (addr < ADR_W'(NREG));
   assign idx     = addr_ok ? addr[AW-1:0] : '0;
   assign go      = frame_ok && !busy && !pre_rise;

   assign wr_en  = go && cmd == OP_WRITE   && addr_ok && wp_n;
   assign st_en  = go && cmd == OP_STORE   && addr_ok && wp_n;
   assign rs_en  = go && cmd == OP_RESTORE && addr_ok;
   assign recall = pre_rise || (go && cmd == OP_RECALL);
   assign rb     = go && (cmd == OP_READ_NV || cmd == OP_READ_SCR) && addr_ok;
   assign start  = st_en || rs_en || (go && cmd == OP_RECALL) || rb;

   assign rb_val    = (cmd == OP_READ_NV) ? nv_flat[idx*DW +: DW] : scr_flat[idx*DW +: DW];
   assign load_word = {cmd, addr, rb_val};

   dpot_regfile #(.NCH(NCH), .DW(DW), .OUT_BITS(OUT_BITS), .NV_DEF(NV_DEF)) u_regs (
      .clk(clk), .por(por), .rst(rst), .recall_all(recall),
      .wr_en(wr_en), .wr_idx(idx), .wr_data(data),
      .st_en(st_en), .st_idx(idx), .rs_en(rs_en), .rs_idx(idx),
      .scr_flat(scr_flat), .nv_flat(nv_flat));

   dpot_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_busy (
      .clk(clk), .rst(any_rst), .start(start), .busy(busy));

   assign ready = !busy;
   assign wiper = scr_flat[NCH*DW-1:0];
   assign dout  = scr_flat[NCH*DW +: OUT_BITS];

   AST_WP_SCR_HOLD: assert property (@(posedge clk) disable iff (any_rst)
      (!wp_n && !recall && !rs_en) |=> $stable(scr_flat)); // R7
   AST_WP_NV_HOLD: assert property (@(posedge clk) disable iff (por)
      !wp_n |=> $stable(nv_flat)); // R7
   AST_PRESET_LOAD: assert property (@(posedge clk) disable iff (any_rst)
      pre_rise |=> (scr_flat == $past(nv_flat))); // R8
   AST_BUSY_READY: assert property (@(posedge clk) disable iff (any_rst)
      start |=> !ready); // R10
   AST_BUSY_DROP: assert property (@(posedge clk) disable iff (any_rst)
      (frame_ok && busy && !pre_rise) |=> $stable(scr_flat)); // R10
endmodule

// File: tb/dpot_ctrl_test.sv
module dpot_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int BUSY = 200;
   localparam int WATCHDOG = 150000;

   logic clk = 1'b0;
   logic por = 1'b1, rst = 1'b1;
   logic sclk = 1'b0, sdi = 1'b0, cs_n = 1'b1, wp_n = 1'b1, preset = 1'b0;
   logic sdo, ready;
   logic [31:0] wiper;
   logic [1:0]  dout;

   int n_chk = 0, n_fail = 0, cycles = 0;
   bit started = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dpot_ctrl #(.BUSY_CYC(BUSY)) uut (
      .clk(clk), .por(por), .rst(rst), .sclk(sclk), .sdi(sdi), .cs_n(cs_n),
      .wp_n(wp_n), .preset(preset), .sdo(sdo), .ready(ready),
      .wiper(wiper), .dout(dout));

   // behavioural reference model
   int m_scr[5], m_nv[5], m_busy, m_cnt;
   bit m_sq, m_cq, m_pq;
   logic [15:0] m_hist;

   always @(posedge clk) begin
      bit srise, crise, prise, ld, st;
      int c, a, d;
      logic [15:0] rbw;
      started = 1;
      if (por) for (int i = 0; i < 5; i++) m_nv[i] = (i < 4) ? 32'h20 : 0;
      if (por || rst) begin
         for (int i = 0; i < 5; i++) m_scr[i] = m_nv[i];
         m_busy = 0; m_cnt = 0; m_hist = '0; m_sq = 1; m_cq = 1; m_pq = preset;
      end else begin
         srise = sclk && !m_sq; crise = cs_n && !m_cq; prise = preset && !m_pq;
         ld = 0; st = 0; rbw = '0;
         c = int'(m_hist[15:12]); a = int'(m_hist[11:8]); d = int'(m_hist[7:0]);
         if (prise) begin
            for (int i = 0; i < 5; i++) m_scr[i] = m_nv[i];
         end else if (crise && m_cnt == 16 && m_busy == 0) begin
            if (c == 8) begin
               for (int i = 0; i < 5; i++) m_scr[i] = m_nv[i];
               st = 1;
            end else if (a <= 4) begin
               if (c == 1 && wp_n) m_scr[a] = (a < 4) ? d : (d & 3);
               else if (c == 2 && wp_n) begin m_nv[a] = m_scr[a]; st = 1; end
               else if (c == 3) begin m_scr[a] = m_nv[a]; st = 1; end
               else if (c == 9 || c == 10) begin
                  rbw = {4'(c), 4'(a), 8'((c == 9) ? m_nv[a] : m_scr[a])};
                  ld = 1; st = 1;
               end
            end
         end
         if (st) m_busy = BUSY; else if (m_busy > 0) m_busy--;
         if (ld) m_hist = rbw;
         else if (srise && !cs_n) m_hist = {m_hist[14:0], sdi};
         if (crise) m_cnt = 0; else if (srise && !cs_n && m_cnt < 17) m_cnt++;
         m_sq = sclk; m_cq = cs_n; m_pq = preset;
      end
   end

   // cycle-by-cycle comparison
   always @(negedge clk) begin
      logic [31:0] ew;
      if (started) begin
         ew = {8'(m_scr[3]), 8'(m_scr[2]), 8'(m_scr[1]), 8'(m_scr[0])};
         n_chk++;
         if (wiper !== ew || dout !== 2'(m_scr[4]) || sdo !== m_hist[15] || ready !== (m_busy == 0)) begin
            n_fail++;
            $display("FAIL R4/R3/R10 model: wiper=%h dout=%0d sdo=%b ready=%b expected %h %0d %b %b",
                     wiper, dout, sdo, ready, ew, m_scr[4], m_hist[15], m_busy == 0);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
         $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic shift_frame(logic [16:0] w, int nbits, output logic [15:0] seen);
      seen = '0;
      cs_n = 0; tick(1);
      for (int i = nbits - 1; i >= 0; i--) begin
         sdi = w[i]; tick(1);
         seen = {seen[14:0], sdo};
         sclk = 1; tick(2);
         sclk = 0; tick(1);
      end
      cs_n = 1; tick(2);
   endtask

   task automatic send(int c, int a, int d);
      logic [15:0] s;
      shift_frame({1'b0, 4'(c), 4'(a), 8'(d)}, 16, s);
   endtask

   task automatic wait_ready();
      while (!ready) tick(1);
   endtask

   initial begin
      logic [15:0] seen;
      tick(3); por = 0; rst = 0; tick(2);
      chk("R9 R11 reset wipers", wiper, 32'h20202020);
      chk("R9 reset dout", 32'(dout), 0);
      chk("R11 reset ready", 32'(ready), 1);

      send(1, 1, 8'h5A);
      chk("R1 R4 write wiper1", wiper, 32'h20205A20);
      send(1, 4, 8'hFF);
      chk("R4 write outputs", 32'(dout), 3);
      send(1, 6, 8'h12);
      chk("R4 bad address wipers", wiper, 32'h20205A20);
      chk("R4 bad address dout", 32'(dout), 3);

      shift_frame({2'b0, 4'd1, 4'd0, 7'h33}, 15, seen);
      chk("R2 short frame ignored", wiper, 32'h20205A20);
      shift_frame({1'b1, 4'd1, 4'd0, 8'h33}, 17, seen);
      chk("R2 long frame ignored", wiper, 32'h20205A20);

      send(0, 1, 8'h23);
      shift_frame(17'h0, 16, seen);
      chk("R3 sdo passthrough", 32'(seen), 32'h0123);

      send(2, 1, 0);
      chk("R10 ready low after store", 32'(ready), 0);
      wait_ready();
      send(1, 1, 8'h11);
      chk("R4 overwrite wiper1", wiper, 32'h20201120);
      send(3, 1, 0);
      chk("R5 restore wiper1", wiper, 32'h20205A20);
      wait_ready();

      send(2, 0, 0);
      send(1, 0, 8'h66);
      chk("R10 frame ignored while busy", wiper, 32'h20205A20);
      wait_ready();

      send(9, 1, 0); wait_ready();
      shift_frame(17'h0, 16, seen);
      chk("R6 readback shadow", 32'(seen), 32'h915A);
      send(10, 4, 0); wait_ready();
      shift_frame(17'h0, 16, seen);
      chk("R6 readback outputs", 32'(seen), 32'hA403);

      wp_n = 0; tick(1);
      send(1, 0, 8'h77);
      chk("R7 write blocked", wiper, 32'h20205A20);
      send(2, 4, 0);
      chk("R7 store blocked no busy", 32'(ready), 1);
      send(8, 0, 0);
      chk("R7 R5 recall all under protect", 32'(dout), 0);
      wait_ready();
      wp_n = 1; tick(1);

      send(1, 2, 8'h99);
      chk("R4 write wiper2", wiper, 32'h20995A20);
      preset = 1; tick(2); preset = 0; tick(1);
      chk("R8 preset reload", wiper, 32'h20205A20);

      send(1, 3, 8'h44);
      chk("R4 write wiper3", wiper, 32'h44205A20);
      rst = 1; tick(2); rst = 0; tick(1);
      chk("R11 reset reload wipers", wiper, 32'h20205A20);
      chk("R11 reset sdo", 32'(sdo), 0);

      tick(2);
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule